// File: doc/BRIEF.md
# Exception Entry Unit with Mode-Banked Registers

This unit sits on the processor side of a core and performs the state changes needed to take an exception. Requests arrive on a seven-bit vector. After masking, one request is chosen by fixed priority. On the next clock edge the unit performs the whole entry in a single step. It saves the current status word into the saved status register that belongs to the target mode, and it switches the mode field. It clears the compact-instruction state bit and sets the interrupt disable bits. It writes the supplied return address into the target mode's link register and loads the program counter with the exception vector.

The unit also holds the general register file. The file is stored as physical copies that are selected by the current mode. Registers 0 to 7 are shared by all modes. Registers 8 to 12 have a second copy that only the fast interrupt mode uses. Registers 13 and 14 have one copy for each exception mode and one copy shared by user and system mode.

A return operation copies the current mode's saved status back into the status word and loads the program counter from a supplied address. Instruction decode, the pipeline and memory all sit outside this unit.

Status word layout: [2:0] mode (user 0, fast interrupt 1, interrupt 2, supervisor 3, abort 4, undefined 5, system 6), [3] compact-instruction state, [4] fast-interrupt disable, [5] interrupt disable, [7:6] general flags.

Top module: `trap_entry_unit`

## Requirements
- R1: Vectors are offsets from VEC_BASE (default 0): reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C. pc_o holds the vector and pc_load_o is 1 in the cycle after the request.
- R2: Reset and supervisor call enter supervisor mode (3). Both aborts enter abort mode (4). Undefined enters undefined mode (5). Interrupt enters mode 2 and fast interrupt enters mode 1.
- R3: On entry, the status word as it was before entry is stored in the target mode's saved status, and saved_status_o shows it.
- R4: On entry, status bit 3 is cleared.
- R5: On entry, ret_addr_i is written into register 14 of the target mode.
- R6: Registers 13 and 14 are banked per mode: user and system share one copy, and each exception mode has its own. Registers 0 to 7 are shared by every mode. Reading address 15 returns pc_o.
- R7: Fast interrupt mode uses its own copy of registers 8 to 12. All other modes use the common copy.
- R8: exc_req_i bits are reset 0, data abort 1, fast interrupt 2, interrupt 3, prefetch abort 4, undefined 5, supervisor call 6. The lowest set bit wins.
- R9: Entry to either interrupt mode, or by reset, sets bit 5. Entry to fast interrupt mode or by reset also sets bit 4. Other entries leave bits 4 and 5 unchanged. A request on bit 3 is ignored while bit 5 is set, and a request on bit 2 is ignored while bit 4 is set.
- R10: eret_i in a mode that has a saved status restores the status word from it, loads pc_o from eret_addr_i and pulses pc_load_o, all on the same edge.
- R11: User and system modes have no saved status: saved_status_o reads 0 and eret_i has no effect. A status write in user mode keeps the mode field at user. A privileged write of mode value 7 keeps the current mode.
- R12: An accepted exception takes priority over eret_i, status writes and register writes that arrive in the same cycle, and those are dropped. The asynchronous reset gives status 0x33, pc_o 0 and all registers 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 7 | Exception requests, bit order as in R8 |
| ret_addr_i | input | XLEN | Return address saved to the link register on entry |
| eret_i | input | 1 | Return from exception |
| eret_addr_i | input | XLEN | Program counter target of a return |
| sr_we_i | input | 1 | Status word write enable |
| sr_wdata_i | input | 8 | Status word write data |
| rf_we_i | input | 1 | Register write enable |
| rf_waddr_i | input | 4 | Register write address |
| rf_wdata_i | input | XLEN | Register write data |
| rf_raddr_i | input | 4 | Register read address |
| rf_rdata_o | output | XLEN | Register read data for the current mode |
| status_o | output | 8 | Current status word |
| saved_status_o | output | 8 | Saved status of the current mode |
| pc_o | output | XLEN | Program counter value |
| pc_load_o | output | 1 | Program counter was redirected on the last edge |

## Verification
Entry, return, status writes and register writes all take effect on the first rising edge after the stimulus is driven. status_o, saved_status_o, pc_o and pc_load_o are registered, so they carry the new values for exactly the following cycle. rf_rdata_o is combinational from the registered state and the current mode. The bench therefore drives inputs just after an edge and checks every registered output one edge later. For reads, it changes rf_raddr_i and samples after a short settling delay within the same cycle. After each request, pc_load_o is checked again one edge later to confirm that it was a single-cycle pulse.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    M_USR = 3'd0, M_FIQ = 3'd1, M_IRQ = 3'd2, M_SVC = 3'd3,
    M_ABT = 3'd4, M_UND = 3'd5, M_SYS = 3'd6
  } mode_e;

  // value equals request bit index and priority rank (0 highest)
  typedef enum logic [2:0] {
    X_RST = 3'd0, X_DABT = 3'd1, X_FIQ = 3'd2, X_IRQ = 3'd3,
    X_PABT = 3'd4, X_UND = 3'd5, X_SVC = 3'd6
  } exc_e;

  localparam int NUM_EXC = 7;
  localparam int SR_W    = 8;
  localparam int SR_T    = 3;
  localparam int SR_F    = 4;
  localparam int SR_I    = 5;
  localparam int NUM_BANKS = 6;  // usr/sys, fiq, irq, svc, abt, und
  localparam int NUM_PHYS  = 8 + 5 + 5 + 2 * NUM_BANKS;
  localparam logic [SR_W-1:0] SR_RESET = 8'h33;

  function automatic logic [4:0] vec_off(exc_e k);
    case (k)
      X_RST:   return 5'h00;
      X_UND:   return 5'h04;
      X_SVC:   return 5'h08;
      X_PABT:  return 5'h0C;
      X_DABT:  return 5'h10;
      X_IRQ:   return 5'h18;
      default: return 5'h1C;
    endcase
  endfunction

  function automatic mode_e tgt_mode(exc_e k);
    case (k)
      X_RST, X_SVC:   return M_SVC;
      X_DABT, X_PABT: return M_ABT;
      X_UND:          return M_UND;
      X_IRQ:          return M_IRQ;
      default:        return M_FIQ;
    endcase
  endfunction

  function automatic logic [2:0] bank_slot(mode_e m);
    case (m)
      M_FIQ:   return 3'd1;
      M_IRQ:   return 3'd2;
      M_SVC:   return 3'd3;
      M_ABT:   return 3'd4;
      M_UND:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int N = 7,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  grant_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
    valid_o = |req_i;
    grant_o = valid_o ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/trap_bank_map.sv
module trap_bank_map
  import trap_pkg::*;
#(
  parameter int AW = 4,
  localparam int IW = $clog2(NUM_PHYS)
) (
  input  mode_e         mode_i,
  input  logic [AW-1:0] addr_i,
  output logic [IW-1:0] idx_o
);
  logic [2:0] slot;

  always_comb begin
    slot = bank_slot(mode_i);
    if (addr_i < AW'(8)) begin
      idx_o = IW'(addr_i);
    end else if (addr_i < AW'(13)) begin
      idx_o = (slot == 3'd1) ? IW'(addr_i) + IW'(5) : IW'(addr_i);
    end else if (addr_i < AW'(15)) begin
      idx_o = IW'(18) + IW'({slot, 1'b0}) + IW'(addr_i - AW'(13));
    end else begin
      idx_o = '0;  // program counter handled by the caller
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EXC-1:0]   exc_req_i,
  input  logic [XLEN-1:0]      ret_addr_i,
  input  logic                 eret_i,
  input  logic [XLEN-1:0]      eret_addr_i,
  input  logic                 sr_we_i,
  input  logic [SR_W-1:0]      sr_wdata_i,
  input  logic                 rf_we_i,
  input  logic [3:0]           rf_waddr_i,
  input  logic [XLEN-1:0]      rf_wdata_i,
  input  logic [3:0]           rf_raddr_i,
  output logic [XLEN-1:0]      rf_rdata_o,
  output logic [SR_W-1:0]      status_o,
  output logic [SR_W-1:0]      saved_status_o,
  output logic [XLEN-1:0]      pc_o,
  output logic                 pc_load_o
);
  localparam int PIW = $clog2(NUM_PHYS);
  localparam int KW  = $clog2(NUM_EXC);

  logic [SR_W-1:0] status_q;
  logic [SR_W-1:0] spsr_q [NUM_BANKS-1];
  logic [XLEN-1:0] regs_q [NUM_PHYS];
  logic [XLEN-1:0] pc_q;
  logic            pc_load_q, entry_q;

  mode_e      cur_mode, new_mode;
  logic [2:0] cur_slot, new_slot;
  exc_e       kind;

  logic [NUM_EXC-1:0] eff_req, arb_grant;
  logic               arb_valid;
  logic [KW-1:0]      arb_idx;
  logic [PIW-1:0]     rd_idx, wr_idx, lr_idx;
  logic [SR_W-1:0]    entry_sr, wr_sr;
  logic               can_ret;

  assign cur_mode = mode_e'(status_q[2:0]);
  assign cur_slot = bank_slot(cur_mode);
  assign can_ret  = (cur_slot != 3'd0);

  always_comb begin
    eff_req = exc_req_i;
    if (status_q[SR_I]) eff_req[X_IRQ] = 1'b0;
    if (status_q[SR_F]) eff_req[X_FIQ] = 1'b0;
  end

  trap_arbiter #(.N(NUM_EXC)) u_arb (
    .req_i  (eff_req),
    .valid_o(arb_valid),
    .idx_o  (arb_idx),
    .grant_o(arb_grant)
  );

  assign kind     = exc_e'(arb_idx);
  assign new_mode = tgt_mode(kind);
  assign new_slot = bank_slot(new_mode);

  trap_bank_map u_rd_map (.mode_i(cur_mode), .addr_i(rf_raddr_i), .idx_o(rd_idx));
  trap_bank_map u_wr_map (.mode_i(cur_mode), .addr_i(rf_waddr_i), .idx_o(wr_idx));
  trap_bank_map u_lr_map (.mode_i(new_mode), .addr_i(4'd14),      .idx_o(lr_idx));

  always_comb begin
    entry_sr       = status_q;
    entry_sr[2:0]  = new_mode;
    entry_sr[SR_T] = 1'b0;
    if (kind inside {X_RST, X_FIQ, X_IRQ}) entry_sr[SR_I] = 1'b1;
    if (kind inside {X_RST, X_FIQ})        entry_sr[SR_F] = 1'b1;
  end

  // user mode cannot leave itself; mode code 7 is not a mode
  always_comb begin
    wr_sr = sr_wdata_i;
    if (cur_mode == M_USR || sr_wdata_i[2:0] == 3'd7) wr_sr[2:0] = status_q[2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= SR_RESET;
      pc_q      <= '0;
      pc_load_q <= 1'b0;
      entry_q   <= 1'b0;
      for (int k = 0; k < NUM_BANKS - 1; k++) spsr_q[k] <= '0;
      for (int k = 0; k < NUM_PHYS; k++)      regs_q[k] <= '0;
    end else begin
      pc_load_q <= 1'b0;
      entry_q   <= 1'b0;
      if (arb_valid) begin
        spsr_q[new_slot - 3'd1] <= status_q;
        status_q                <= entry_sr;
        regs_q[lr_idx]          <= ret_addr_i;
        pc_q                    <= VEC_BASE + XLEN'(vec_off(kind));
        pc_load_q               <= 1'b1;
        entry_q                 <= 1'b1;
      end else begin
        if (eret_i && can_ret) begin
          status_q  <= spsr_q[cur_slot - 3'd1];
          pc_q      <= eret_addr_i;
          pc_load_q <= 1'b1;
        end else if (sr_we_i) begin
          status_q <= wr_sr;
        end
        if (rf_we_i && rf_waddr_i != 4'd15) regs_q[wr_idx] <= rf_wdata_i;
      end
    end
  end

  assign rf_rdata_o     = (rf_raddr_i == 4'd15) ? pc_q : regs_q[rd_idx];
  assign status_o       = status_q;
  assign saved_status_o = can_ret ? spsr_q[cur_slot - 3'd1] : '0;
  assign pc_o           = pc_q;
  assign pc_load_o      = pc_load_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [SR_W-1:0]    status_i,
  input logic [XLEN-1:0]    pc_i,
  input logic               pc_load_i,
  input logic               entry_i,
  input logic [NUM_EXC-1:0] grant_i,
  input logic [XLEN-1:0]    eret_addr_i
);
  // R4
  thumb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |-> !status_i[SR_T]);

  // R9
  irq_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_i && status_i[2:0] inside {3'd1, 3'd2}) |-> status_i[SR_I]);

  // R8
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  // R1
  vector_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |-> (pc_load_i && pc_i[1:0] == 2'b00));

  // R10
  return_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_i && !entry_i) |-> pc_i == $past(eret_addr_i));

  // R11
  user_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_i[2:0]) == 3'd0 && !entry_i) |-> status_i[2:0] == 3'd0);
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_o),
  .pc_i       (pc_o),
  .pc_load_i  (pc_load_o),
  .entry_i    (entry_q),
  .grant_i    (arb_grant),
  .eret_addr_i(eret_addr_i)
);

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  exc_req = '0;
  logic [31:0] ret_addr = '0, eret_addr = '0, rf_wdata = '0;
  logic        eret = 1'b0, sr_we = 1'b0, rf_we = 1'b0;
  logic [7:0]  sr_wdata = '0;
  logic [3:0]  rf_waddr = '0, rf_raddr = '0;
  logic [31:0] rf_rdata, pc;
  logic [7:0]  status, saved;
  logic        pc_load;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  trap_entry_unit i_trap_entry_unit (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .ret_addr_i(ret_addr),
    .eret_i(eret), .eret_addr_i(eret_addr), .sr_we_i(sr_we), .sr_wdata_i(sr_wdata),
    .rf_we_i(rf_we), .rf_waddr_i(rf_waddr), .rf_wdata_i(rf_wdata),
    .rf_raddr_i(rf_raddr), .rf_rdata_o(rf_rdata), .status_o(status),
    .saved_status_o(saved), .pc_o(pc), .pc_load_o(pc_load)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_sr(logic [7:0] v);
    sr_we = 1'b1; sr_wdata = v; tick(); sr_we = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d; tick(); rf_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    rf_raddr = a; #1; chk(tag, rf_rdata, exp);
  endtask

  task automatic take(logic [6:0] r, logic [31:0] ra);
    exc_req = r; ret_addr = ra; tick(); exc_req = '0;
  endtask

  task automatic do_ret(logic [31:0] a);
    eret = 1'b1; eret_addr = a; tick(); eret = 1'b0;
  endtask

  task automatic entry_chk(string tag, logic [31:0] vec, logic [7:0] st, logic [7:0] sv);
    chk({tag, " pc_load"}, 32'(pc_load), 32'd1);
    chk({tag, " vector"}, pc, vec);
    chk({tag, " status"}, 32'(status), 32'(st));
    chk({tag, " saved"}, 32'(saved), 32'(sv));
  endtask

  task automatic t_reset();
    chk("R12 reset status", 32'(status), 32'h33);
    chk("R12 reset pc", pc, 32'h0);
    chk("R12 reset pc_load", 32'(pc_load), 32'd0);
    rd("R12 reset r5", 4'd5, 32'h0);
  endtask

  task automatic t_bank();
    wr(4'd13, 32'h1111); wr(4'd14, 32'h2222); wr(4'd0, 32'hA0);
    set_sr(8'h36);  // system mode
    wr(4'd13, 32'h3333);
    rd("R6 sys r13", 4'd13, 32'h3333);
    rd("R6 sys r14", 4'd14, 32'h0);
    rd("R6 shared r0", 4'd0, 32'hA0);
    set_sr(8'h33);
    rd("R6 svc r13", 4'd13, 32'h1111);
    rd("R6 svc r14", 4'd14, 32'h2222);
  endtask

  task automatic t_fiq();
    set_sr(8'h0E);  // system, T set, unmasked
    wr(4'd8, 32'h88);
    take(7'b000_0100, 32'h400);
    entry_chk("R1 R2 R3 R4 R9 fiq", 32'h1C, 8'h31, 8'h0E);
    rd("R5 fiq lr", 4'd14, 32'h400);
    rd("R7 fiq r8", 4'd8, 32'h0);
    rd("R6 fiq r13", 4'd13, 32'h0);
    rd("R6 fiq r0", 4'd0, 32'hA0);
    rd("R6 r15", 4'd15, 32'h1C);
    tick();
    chk("R1 pc_load pulse", 32'(pc_load), 32'd0);
    do_ret(32'h500);
    chk("R10 ret status", 32'(status), 32'h0E);
    chk("R10 ret pc", pc, 32'h500);
    chk("R10 ret pc_load", 32'(pc_load), 32'd1);
    rd("R7 sys r8", 4'd8, 32'h88);
  endtask

  task automatic t_irq_mask();
    set_sr(8'h2E);
    take(7'b000_1000, 32'h600);
    chk("R9 masked irq status", 32'(status), 32'h2E);
    chk("R9 masked irq pc_load", 32'(pc_load), 32'd0);
    set_sr(8'h0E);
    take(7'b000_1000, 32'h600);
    entry_chk("R1 R2 R9 irq", 32'h18, 8'h22, 8'h0E);
    rd("R5 irq lr", 4'd14, 32'h600);
    do_ret(32'h0);
  endtask

  task automatic t_prio();
    take(7'b111_1110, 32'h10);
    entry_chk("R8 dabt wins", 32'h10, 8'h04, 8'h0E);
    set_sr(8'h0E);
    take(7'b111_1100, 32'h11);
    entry_chk("R8 fiq wins", 32'h1C, 8'h31, 8'h0E);
    do_ret(32'h0);
    take(7'b111_1000, 32'h12);
    entry_chk("R8 irq wins", 32'h18, 8'h22, 8'h0E);
    do_ret(32'h0);
    take(7'b111_0000, 32'h13);
    entry_chk("R8 pabt wins", 32'h0C, 8'h04, 8'h0E);
    do_ret(32'h0);
    take(7'b110_0000, 32'h14);
    entry_chk("R8 und wins", 32'h04, 8'h05, 8'h0E);
    do_ret(32'h0);
    take(7'b100_0000, 32'h15);
    entry_chk("R2 svc", 32'h08, 8'h03, 8'h0E);
    do_ret(32'h0);
    take(7'b111_1111, 32'h16);
    entry_chk("R8 reset wins", 32'h00, 8'h33, 8'h0E);
  endtask

  task automatic t_user();
    set_sr(8'hC0);
    chk("R11 enter user", 32'(status), 32'hC0);
    set_sr(8'h03);
    chk("R11 user keeps mode", 32'(status), 32'h00);
    chk("R11 user no saved", 32'(saved), 32'h0);
    do_ret(32'h700);
    chk("R11 user ret ignored pc_load", 32'(pc_load), 32'd0);
    chk("R11 user ret ignored status", 32'(status), 32'h00);
    rd("R6 user r13", 4'd13, 32'h3333);
    rf_we = 1'b1; rf_waddr = 4'd0; rf_wdata = 32'hDEAD;
    sr_we = 1'b1; sr_wdata = 8'hC0;
    take(7'b100_0000, 32'h800);
    rf_we = 1'b0; sr_we = 1'b0;
    entry_chk("R12 svc from user", 32'h08, 8'h03, 8'h00);
    rd("R12 write dropped", 4'd0, 32'hA0);
    rd("R5 svc lr", 4'd14, 32'h800);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_bank();
    t_fiq();
    t_irq_mask();
    t_prio();
    t_user();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule